// File: doc/BRIEF.md
# Lane Alignment Sequencer

This block sits on one transmit lane of a multi-gigabit serial converter link, just ahead of the 8b/10b encoder. It emits octets with a control flag. While the receiver has not confirmed code group synchronization, it sends the comma character. Once synchronization is reported, it waits for the next multiframe boundary. It then either sends a lane alignment sequence built from whole multiframes, or goes straight to user data. In a link-layer test mode it sends the alignment sequence without end. A local counter of octets, frames and multiframes sets every position. This counter advances only on octets the encoder accepts, so the multiframe phase is kept through stalls and losses of synchronization.

In the user-data phase the block works as a pass-through stream. Unused tail bits of each octet, marked by a per-octet mask, are forced to zero or filled from a 31-bit pseudo-random register. At the last octet of a frame, an octet that repeats the previous frame's last octet is replaced by a frame or multiframe alignment control character, unless that substitution is disabled. Both interfaces use valid/ready. Input is taken only in the data phase and only when the encoder is ready. A stalled output keeps its octet and flag unchanged until it is taken. The configuration inputs are only to be changed while the power-down input is high.

Top module: `lasq_tx_sequencer`

## Requirements
- R1: While `cfg_pwrdn` is high, `out_valid` and `in_ready` are low. All state returns to its start: comma phase, counters at position zero, and the pseudo-random register seeded with all ones.
- R2: In the comma phase every octet is 0xBC with `out_k`=1. The comma phase is left only after the octet at multiframe position MF_LEN-1 is taken with `sync_done` high. Whenever `sync_done` is low at a clock edge, the block is in the comma phase from the next cycle.
- R3: With `cfg_mode`=01, the alignment sequence lasts exactly 4*(`cfg_repeat`+1) multiframes and is followed by the data phase.
- R4: In an alignment multiframe, position 0 is 0x1C (K) and position MF_LEN-1 is 0x7C (K). In a multiframe whose index within the sequence is 1 mod 4, position 1 is 0x9C (K) and position p (2..MF_LEN-2) carries byte p-2 of `cfg_ilas_data`, where byte 0 is bits 7:0. Every other octet is the position number with `out_k`=0.
- R5: With `cfg_mode`=00 or 10, the block goes from the comma phase straight to the data phase and sends no alignment multiframes.
- R6: With `cfg_mode`=11, alignment multiframes repeat without end and `in_ready` stays low.
- R7: In the data phase `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. A data octet not replaced by an alignment character leaves with `out_k`=0.
- R8: Bits set in `in_tail_mask` are replaced. When `cfg_tail_en`=1 they take the matching bits of state[7:0] of a Fibonacci register with polynomial x^31+x^28+1 (next = {s[29:0], s[30]^s[27]}), seeded with all ones, which steps once per accepted data octet. When `cfg_tail_en`=0 those bits are 0.
- R9: At the last octet of a frame, if the filled octet equals the previous frame's last filled octet of the same data run, it is sent as 0x7C (K) at the end of a multiframe and as 0xFC (K) elsewhere. The first frame of a data run is never replaced.
- R10: With `cfg_fa_dis`=1 no data octet is replaced.
- R11: While `out_valid` is high and `out_ready` is low, with `sync_done` high, the next cycle shows the same `out_data` and `out_k` with `out_valid` still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pwrdn | input | 1 | Holds the lane in its reset state |
| cfg_mode | input | 2 | Sequence mode: 00 off, 01 once, 10 as off, 11 endless |
| cfg_repeat | input | REP_W | Extra repetitions of the alignment sequence |
| cfg_fa_dis | input | 1 | Disables alignment character substitution |
| cfg_tail_en | input | 1 | Fills tail bits with pseudo-random bits |
| cfg_ilas_data | input | 8*(MF_LEN-3) | Configuration octets for the second multiframe |
| sync_done | input | 1 | Code group synchronization reported by the receiver |
| in_valid | input | 1 | Raw octet valid |
| in_ready | output | 1 | Raw octet taken |
| in_data | input | 8 | Raw octet |
| in_tail_mask | input | 8 | Tail bits of the raw octet to be filled |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Encoder accepts the octet |
| out_data | output | 8 | Octet to the encoder |
| out_k | output | 1 | Octet is a control character |

## Verification
Repeat counts of 0, 1, 5, 255 and random small values, each counted in alignment multiframes, separate an off-by-one in the sequence length from a wrong position of the start or end markers. Raw data drawn from only three values makes repeated frame endings common. This exposes the substitution, the choice between the two characters at multiframe end, and the effect of the disable bit. Random tail masks with the fill on and off separate the pseudo-random bits from zero fill. Random encoder stalls, and a loss of synchronization in mid-data, show that positions advance only on taken octets and that the comma phase returns.

// File: rtl/lasq_pkg.sv
package lasq_pkg;
  typedef enum logic [1:0] {PH_CGS, PH_ILAS, PH_DATA} phase_e;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } octet_t;

  localparam logic [7:0] K_COMMA = 8'hBC;
  localparam logic [7:0] K_MF_START = 8'h1C;
  localparam logic [7:0] K_MF_ALIGN = 8'h7C;
  localparam logic [7:0] K_CFG_MARK = 8'h9C;
  localparam logic [7:0] K_FR_ALIGN = 8'hFC;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_ONCE = 2'b01;
  localparam logic [1:0] MODE_LOOP = 2'b11;
endpackage

// File: rtl/lasq_lmfc.sv
module lasq_lmfc #(
  parameter int F = 2,
  parameter int K = 4,
  localparam int MF_LEN = F * K,
  localparam int POS_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [POS_W-1:0] pos,
  output logic             frm_end,
  output logic             mf_end
);
  localparam int OW = (F > 1) ? $clog2(F) : 1;
  localparam int KW = (K > 1) ? $clog2(K) : 1;

  logic [OW-1:0] oct_q;
  logic [KW-1:0] frm_q;

  assign frm_end = (oct_q == OW'(F - 1));
  assign mf_end  = frm_end && (frm_q == KW'(K - 1));
  assign pos     = POS_W'(int'(frm_q) * F + int'(oct_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_q <= '0;
      frm_q <= '0;
    end else if (clr) begin
      oct_q <= '0;
      frm_q <= '0;
    end else if (adv) begin
      if (frm_end) begin
        oct_q <= '0;
        frm_q <= mf_end ? '0 : frm_q + 1'b1;
      end else begin
        oct_q <= oct_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lasq_tail_fill.sv
module lasq_tail_fill #(
  parameter int LFSR_W = 31,
  parameter int TAP    = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       en,
  input  logic [7:0] din,
  input  logic [7:0] mask,
  output logic [7:0] dout
);
  logic [LFSR_W-1:0] s_q;
  logic [LFSR_W-1:0] s_nxt;
  logic [7:0]        fill_bits;

  assign s_nxt     = {s_q[LFSR_W-2:0], s_q[LFSR_W-1] ^ s_q[TAP-1]};
  assign fill_bits = en ? s_q[7:0] : 8'h00;
  assign dout      = (din & ~mask) | (fill_bits & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= '1;
    else if (clr)  s_q <= '1;
    else if (step) s_q <= s_nxt;
  end
endmodule

// File: rtl/lasq_ilas_gen.sv
module lasq_ilas_gen
  import lasq_pkg::*;
#(
  parameter int MF_LEN = 8,
  localparam int POS_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
  localparam int CFG_LEN = MF_LEN - 3
) (
  input  logic [POS_W-1:0]     pos,
  input  logic [1:0]           mf_idx,
  input  logic [CFG_LEN*8-1:0] cfg,
  output octet_t               oct
);
  logic [7:0] cfg_byte;

  always_comb begin
    cfg_byte = 8'h00;
    for (int i = 0; i < CFG_LEN; i++) begin
      if (pos == POS_W'(i + 2)) cfg_byte = cfg[i*8 +: 8];
    end
  end

  always_comb begin
    oct = '{k: 1'b0, d: 8'(pos)};
    if (pos == '0) begin
      oct = '{k: 1'b1, d: K_MF_START};
    end else if (pos == POS_W'(MF_LEN - 1)) begin
      oct = '{k: 1'b1, d: K_MF_ALIGN};
    end else if (mf_idx == 2'd1) begin
      if (pos == POS_W'(1)) oct = '{k: 1'b1, d: K_CFG_MARK};
      else                  oct = '{k: 1'b0, d: cfg_byte};
    end
  end
endmodule

// File: rtl/lasq_frame_align.sv
module lasq_frame_align
  import lasq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       fire,
  input  logic       at_frame_end,
  input  logic       at_mf_end,
  input  logic       dis,
  input  logic [7:0] din,
  output octet_t     dout
);
  logic [7:0] prev_q;
  logic       prev_vld_q;
  logic       subst;

  assign subst = !dis && prev_vld_q && at_frame_end && (din == prev_q);

  always_comb begin
    if (subst) dout = '{k: 1'b1, d: at_mf_end ? K_MF_ALIGN : K_FR_ALIGN};
    else       dout = '{k: 1'b0, d: din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (clr) begin
      prev_vld_q <= 1'b0;
    end else if (fire && at_frame_end) begin
      prev_q     <= din;
      prev_vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lasq_tx_sequencer.sv
module lasq_tx_sequencer
  import lasq_pkg::*;
#(
  parameter int OCTS_PER_FRAME = 2,
  parameter int FRAMES_PER_MF  = 4,
  parameter int REP_W          = 8,
  localparam int MF_LEN  = OCTS_PER_FRAME * FRAMES_PER_MF,
  localparam int CFG_LEN = MF_LEN - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_pwrdn,
  input  logic [1:0]           cfg_mode,
  input  logic [REP_W-1:0]     cfg_repeat,
  input  logic                 cfg_fa_dis,
  input  logic                 cfg_tail_en,
  input  logic [CFG_LEN*8-1:0] cfg_ilas_data,
  input  logic                 sync_done,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic [7:0]           in_tail_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_k
);
  localparam int POS_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam int CNT_W = REP_W + 2;

  phase_e           phase;
  logic [CNT_W-1:0] ilas_cnt;
  logic [POS_W-1:0] mf_pos;
  logic             frm_end, mf_end;
  logic             fire, data_fire;
  logic             ilas_last, ilas_on;
  logic [7:0]       filled;
  octet_t           ilas_oct, data_oct;

  assign fire      = out_valid && out_ready;
  assign data_fire = fire && (phase == PH_DATA);
  assign ilas_last = (ilas_cnt == {cfg_repeat, 2'b11});
  assign ilas_on   = (cfg_mode == MODE_ONCE) || (cfg_mode == MODE_LOOP);

  lasq_lmfc #(.F(OCTS_PER_FRAME), .K(FRAMES_PER_MF)) u_lmfc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_pwrdn), .adv(fire),
    .pos(mf_pos), .frm_end(frm_end), .mf_end(mf_end)
  );

  lasq_tail_fill #(.LFSR_W(31), .TAP(28)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr(cfg_pwrdn), .step(data_fire),
    .en(cfg_tail_en), .din(in_data), .mask(in_tail_mask), .dout(filled)
  );

  lasq_ilas_gen #(.MF_LEN(MF_LEN)) u_ilas (
    .pos(mf_pos), .mf_idx(ilas_cnt[1:0]), .cfg(cfg_ilas_data), .oct(ilas_oct)
  );

  lasq_frame_align u_align (
    .clk(clk), .rst_n(rst_n), .clr(cfg_pwrdn || (phase != PH_DATA)),
    .fire(data_fire), .at_frame_end(frm_end), .at_mf_end(mf_end),
    .dis(cfg_fa_dis), .din(filled), .dout(data_oct)
  );

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    out_data  = 8'h00;
    out_k     = 1'b0;
    if (!cfg_pwrdn) begin
      unique case (phase)
        PH_CGS: begin
          out_valid = 1'b1;
          out_k     = 1'b1;
          out_data  = K_COMMA;
        end
        PH_ILAS: begin
          out_valid = 1'b1;
          out_k     = ilas_oct.k;
          out_data  = ilas_oct.d;
        end
        PH_DATA: begin
          out_valid = in_valid;
          in_ready  = out_ready;
          out_k     = data_oct.k;
          out_data  = data_oct.d;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CGS;
      ilas_cnt <= '0;
    end else if (cfg_pwrdn || !sync_done) begin
      phase    <= PH_CGS;
      ilas_cnt <= '0;
    end else if (fire && mf_end) begin
      unique case (phase)
        PH_CGS: begin
          phase    <= ilas_on ? PH_ILAS : PH_DATA;
          ilas_cnt <= '0;
        end
        PH_ILAS: begin
          if (ilas_last) begin
            ilas_cnt <= '0;
            if (cfg_mode != MODE_LOOP) phase <= PH_DATA;
          end else begin
            ilas_cnt <= ilas_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lasq_tx_sequencer_chk.sv
module lasq_tx_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pwrdn,
  input logic [1:0] cfg_mode,
  input logic       sync_done,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_k,
  input logic       at_frame_end
);
  // R1
  pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pwrdn |-> (!out_valid && !in_ready));

  // R2
  sync_loss_comma_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_pwrdn)
    $fell(sync_done) |=> (!out_valid || (out_k && out_data == 8'hBC)));

  // R6
  loop_mode_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b11) |-> !in_ready);

  // R7
  ready_needs_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  // R9
  frame_char_position_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_pwrdn)
    (out_valid && out_k && out_data == 8'hFC) |-> at_frame_end);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_pwrdn)
    (out_valid && !out_ready && sync_done) |=>
      (out_valid && $stable(out_data) && $stable(out_k)));
endmodule

bind lasq_tx_sequencer lasq_tx_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pwrdn(cfg_pwrdn), .cfg_mode(cfg_mode),
  .sync_done(sync_done), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_k(out_k),
  .at_frame_end(frm_end)
);

// File: tb/tb_lasq_tx_sequencer.sv
module tb_lasq_tx_sequencer;
  localparam int F   = 2;
  localparam int K   = 4;
  localparam int MF  = F * K;
  localparam int CFG = MF - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pwrdn = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_repeat = 8'd0;
  logic cfg_fa_dis = 1'b0;
  logic cfg_tail_en = 1'b0;
  logic [CFG*8-1:0] cfg_ilas_data = '0;
  logic sync_done = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic [7:0] in_tail_mask = 8'h00;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic out_k;

  int checks = 0;
  int errors = 0;

  int m_ph, m_pos, m_ilas;
  logic [7:0] m_prev;
  bit m_prevv;
  logic [30:0] m_lfsr;
  int a_cnt, data_cnt;
  bit taken;
  bit stall_pend;
  logic [8:0] stall_val;

  lasq_tx_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_pwrdn(cfg_pwrdn), .cfg_mode(cfg_mode),
    .cfg_repeat(cfg_repeat), .cfg_fa_dis(cfg_fa_dis), .cfg_tail_en(cfg_tail_en),
    .cfg_ilas_data(cfg_ilas_data), .sync_done(sync_done), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_tail_mask(in_tail_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_k(out_k)
  );

  always #4 clk = ~clk;

  task automatic cmp(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmpi(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ilas_exp(int pos, int idx);
    if (pos == 0) return {1'b1, 8'h1C};
    if (pos == MF - 1) return {1'b1, 8'h7C};
    if (idx == 1 && pos == 1) return {1'b1, 8'h9C};
    if (idx == 1) return {1'b0, cfg_ilas_data[(pos-2)*8 +: 8]};
    return {1'b0, 8'(pos)};
  endfunction

  function automatic logic [7:0] fill_exp(logic [7:0] d, logic [7:0] m, bit en, logic [30:0] s);
    return (d & ~m) | ((en ? s[7:0] : 8'h00) & m);
  endfunction

  task automatic model_reset();
    m_ph = 0; m_pos = 0; m_ilas = 0; m_prev = 8'h00; m_prevv = 0;
    m_lfsr = '1; stall_pend = 0;
  endtask

  task automatic step_cycle();
    bit ev, er, ek, fe, me, fire, last;
    logic [7:0] ed, fill;
    int old;
    string req;
    @(negedge clk);
    taken = 0;
    if (cfg_pwrdn) begin
      cmp("R1 quiet in power-down", {7'b0, out_valid, in_ready}, 9'd0);
      model_reset();
    end else begin
      fe = (m_pos % F) == F - 1;
      me = (m_pos == MF - 1);
      fill = fill_exp(in_data, in_tail_mask, cfg_tail_en, m_lfsr);
      ek = 0; ed = 8'h00; ev = 0; er = 0; req = "R7";
      case (m_ph)
        0: begin ev = 1; ek = 1; ed = 8'hBC; req = "R2"; end
        1: begin ev = 1; {ek, ed} = ilas_exp(m_pos, m_ilas % 4);
                 req = (cfg_mode == 2'b11) ? "R6" : "R4"; end
        default: begin
          ev = in_valid; er = out_ready; ed = fill;
          req = cfg_tail_en ? "R8" : "R7";
          if (m_prevv && fe && fill == m_prev) begin
            if (!cfg_fa_dis) begin ek = 1; ed = me ? 8'h7C : 8'hFC; req = "R9"; end
            else req = "R10";
          end
        end
      endcase
      if (stall_pend) cmp("R11 held under stall", {out_k, out_data}, stall_val);
      cmp({req, " handshake"}, {7'b0, out_valid, in_ready}, {7'b0, ev, er});
      if (ev) cmp({req, " octet"}, {out_k, out_data}, {ek, ed});
      fire = ev && out_ready;
      stall_pend = ev && !out_ready && sync_done;
      stall_val = {ek, ed};
      if (fire && m_ph == 1 && ek && ed == 8'h7C) a_cnt++;
      if (fire && m_ph == 2) begin data_cnt++; taken = 1; end
      old = m_ph;
      if (fire && m_ph == 2) begin
        if (fe) begin m_prev = fill; m_prevv = 1; end
        m_lfsr = {m_lfsr[29:0], m_lfsr[30] ^ m_lfsr[27]};
      end
      if (!sync_done) begin
        m_ph = 0; m_ilas = 0;
      end else if (fire && me) begin
        if (m_ph == 0) begin
          m_ph = (cfg_mode == 2'b01 || cfg_mode == 2'b11) ? 1 : 2;
          m_ilas = 0;
        end else if (m_ph == 1) begin
          last = (m_ilas == 4 * int'(cfg_repeat) + 3);
          if (last) begin
            m_ilas = 0;
            if (cfg_mode != 2'b11) m_ph = 2;
          end else m_ilas++;
        end
      end
      if (fire) m_pos = (m_pos + 1) % MF;
      if (old != 2) m_prevv = 0;
    end
    @(posedge clk);
    #1;
    out_ready = ($urandom % 4) != 0;
    if (!in_valid || taken) begin
      in_valid = ($urandom % 5) != 0;
      in_data = 8'($urandom % 3);
      in_tail_mask = 8'($urandom);
    end
  endtask

  task automatic run_case(int mode, int rep, bit fad, bit tail, int ncyc, bit drop);
    cfg_pwrdn = 1'b1;
    sync_done = 1'b0;
    repeat (4) step_cycle();
    cfg_mode = 2'(mode);
    cfg_repeat = 8'(rep);
    cfg_fa_dis = fad;
    cfg_tail_en = tail;
    cfg_ilas_data = {8'($urandom), $urandom};
    cfg_pwrdn = 1'b0;
    a_cnt = 0;
    data_cnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (i == 7) sync_done = 1'b1;
      if (drop && i == ncyc / 2) sync_done = 1'b0;
      if (drop && i == ncyc / 2 + 13) sync_done = 1'b1;
      step_cycle();
    end
    if (!drop) begin
      if (mode == 1) begin
        cmpi("R3 alignment multiframes sent", a_cnt, 4 * (rep + 1));
        cmpi("R3 data follows sequence", int'(data_cnt > 0), 1);
      end else if (mode == 3) begin
        cmpi("R6 no data accepted", data_cnt, 0);
        cmpi("R6 sequence keeps running", int'(a_cnt > 10), 1);
      end else begin
        cmpi("R5 no alignment multiframes", a_cnt, 0);
        cmpi("R5 data reached", int'(data_cnt > 0), 1);
      end
    end else begin
      cmpi("R2 data resumes after resync", int'(data_cnt > 0), 1);
    end
  endtask

  initial begin
    #(8 * 195000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) step_cycle();
    rst_n = 1'b1;
    run_case(1, 0, 0, 0, 400, 0);
    run_case(1, 1, 0, 1, 600, 0);
    run_case(1, 5, 1, 0, 800, 0);
    run_case(0, 0, 0, 0, 300, 0);
    run_case(2, 3, 0, 1, 300, 0);
    run_case(3, 2, 0, 0, 600, 0);
    run_case(1, 0, 0, 1, 600, 1);
    run_case(1, 255, 0, 0, 13000, 0);
    for (int n = 0; n < 6; n++)
      run_case(int'($urandom % 4), int'($urandom % 4), 1'($urandom), 1'($urandom), 500, 0);
    cfg_pwrdn = 1'b1;
    repeat (3) step_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule